// File: doc/BRIEF.md
# Shadow Region Bit-Ownership Filter

This block fronts a shared bank of per-channel DMA control and status registers. It lets several software contexts each reach that bank through a private address window. The bank holds 64 DMA channels and 4 QDMA channels. It keeps a channel-enable word, an interrupt-enable word with set and clear aliases, a completion-pending word, and a QDMA enable nibble. A global window sees every bit of every register. Each of the four shadow windows sees only the channels its region owns.

Ownership is set by per-region masks. Each region has a 64-bit DMA mask and a 4-bit QDMA mask, and a region owns channel n when bit n of its mask is 1. Reads through a shadow window return zero in unowned bit positions. Writes through a shadow window, including the write-one-to-set and write-one-to-clear aliases, change only owned bits. The mask registers themselves can be reached only through the global window. Each region drives its own registered completion interrupt, formed only from owned channels that are both enabled and pending.

The address map uses a 12-bit byte address. The window is `addr[11:8]`: 0 is global, 1 to 4 are shadow regions 0 to 3, and the remaining values are unmapped. Byte offsets within a window:

| Offset | Register |
|---|---|
| 0x00 / 0x04 | channel enable, channels 0..31 / 32..63 |
| 0x08 / 0x0C | interrupt enable |
| 0x10 / 0x14 | interrupt-enable set alias |
| 0x18 / 0x1C | interrupt-enable clear alias |
| 0x20 / 0x24 | pending, read-only |
| 0x28 / 0x2C | pending clear alias |
| 0x30 | QDMA enable, bits 3:0 |
| 0x40 + 0x10·r, +0, +4, +8 | region r DMA mask low, DMA mask high, QDMA mask |

Top module: `shadow_bit_filter`

## Requirements
- R1: After reset, every mask, channel register and pending bit is 0. `intOut` is 0 and `rdData` is 0.
- R2: A write through the global window (addr[11:8]=0) replaces all 32 bits of the addressed half of a register. A read through it returns all bits unmasked.
- R3: A read through shadow window r returns 0 in every bit position whose ownership bit for region r is 0. In owned positions it returns the true value.
- R4: A write to the channel-enable or interrupt-enable register through shadow window r changes only the bits that region r owns.
- R5: Writes to the set alias (OR into interrupt enable) and the clear alias (AND-NOT) through a shadow window have their data masked by the region's ownership first.
- R6: Offset bit 2 selects the high half, which covers channels 32..63 and uses mask bits 63:32. Offset bit 2 at 0 selects channels 0..31 and mask bits 31:0.
- R7: The QDMA enable register, bits 3:0 at offset 0x30, is read-masked and write-merged through the region's 4-bit QDMA mask.
- R8: The mask registers at offset 0x40 and above read as 0 and ignore writes through any shadow window.
- R9: A 1 on `doneIn[n]` sets pending bit n. A 1 written to the pending clear alias clears that bit, masked by ownership when written through a shadow window. If set and clear hit the same bit in the same cycle, the set wins.
- R10: `intOut[r]` is registered. One clock after an edge where some channel is pending, enabled and owned by region r, it is 1. Otherwise it is 0.
- R11: `rdData` holds the read result for the one cycle after a clock edge with `rdEn` high, and is 0 after any other edge. Accesses to an unmapped window read 0 and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte address: window in bits 11:8, word offset in bits 7:2 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| doneIn | input | 64 | Per-channel completion pulses that set pending bits |
| intOut | output | 4 | Per-region completion interrupts |

## Verification
The embedded assertions check several properties on every cycle. A shadow channel-enable write never disturbs unowned bits. A global write lands in full. Shadow read data carries no unowned bits. Completion pulses always leave their pending bits set, and mask registers never move on a shadow access. A region with an all-zero mask never raises its interrupt. Only the directed scenarios can show the exact merged values, the two-region contrast in pending clears, the set-over-clear tie, and the one-cycle delay from a pending change to the interrupt edge.

// File: rtl/shadow_filter_pkg.sv
package shadow_filter_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int NUM_CH      = 64;
  localparam int NUM_QCH     = 4;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int RIDX_W      = $clog2(NUM_REGIONS);
  localparam int WIN_LSB     = 8;
  localparam int OFFS_W      = WIN_LSB - 2;
  localparam int OWN_BASE    = 16;

  typedef enum logic [2:0] {
    RD_NONE, RD_CHEN, RD_IEN, RD_PEND, RD_QEN, RD_OWNLO, RD_OWNHI, RD_QOWN
  } rdsel_e;

  typedef struct packed {
    logic              shadow;
    logic [RIDX_W-1:0] region;
    logic              hiHalf;
    logic              wrChen;
    logic              wrIen;
    logic              setIen;
    logic              clrIen;
    logic              clrPend;
    logic              wrQen;
    logic              wrOwnLo;
    logic              wrOwnHi;
    logic              wrQOwn;
    logic [RIDX_W-1:0] ownIdx;
    logic              rdStb;
    rdsel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import shadow_filter_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0]  win;
  logic [OFFS_W-1:0] offs;
  logic [OFFS_W-1:0] ownRel;
  logic              isGlobal;
  logic              isShadow;

  assign win      = addr[ADDR_W-1:WIN_LSB];
  assign offs     = addr[WIN_LSB-1:2];
  assign ownRel   = offs - OFFS_W'(OWN_BASE);
  assign isGlobal = (win == '0);
  assign isShadow = (win != '0) && (int'(win) <= NUM_REGIONS);

  always_comb begin
    st        = '0;
    st.rdSel  = RD_NONE;
    st.shadow = isShadow;
    st.region = isShadow ? RIDX_W'(win - WIN_W'(1)) : '0;
    st.hiHalf = offs[0];
    st.ownIdx = RIDX_W'(ownRel[OFFS_W-1:2]);
    st.rdStb  = rdEn;
    if (isGlobal || isShadow) begin
      if (int'(offs) < OWN_BASE) begin
        case (offs[3:1])
          3'd0: begin st.wrChen  = wrEn; if (rdEn) st.rdSel = RD_CHEN; end
          3'd1: begin st.wrIen   = wrEn; if (rdEn) st.rdSel = RD_IEN;  end
          3'd2: st.setIen  = wrEn;
          3'd3: st.clrIen  = wrEn;
          3'd4: if (rdEn) st.rdSel = RD_PEND;
          3'd5: st.clrPend = wrEn;
          3'd6: if (!offs[0]) begin
                  st.wrQen = wrEn;
                  if (rdEn) st.rdSel = RD_QEN;
                end
          default: ;
        endcase
      end else if (isGlobal && (int'(ownRel[OFFS_W-1:2]) < NUM_REGIONS)) begin
        case (ownRel[1:0])
          2'd0: begin st.wrOwnLo = wrEn; if (rdEn) st.rdSel = RD_OWNLO; end
          2'd1: begin st.wrOwnHi = wrEn; if (rdEn) st.rdSel = RD_OWNHI; end
          2'd2: begin st.wrQOwn  = wrEn; if (rdEn) st.rdSel = RD_QOWN;  end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sf_datapath.sv
module sf_datapath
  import shadow_filter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_CH-1:0]  doneIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_REGIONS-1:0] intOut
);
  logic [NUM_CH-1:0]  own  [NUM_REGIONS];
  logic [NUM_QCH-1:0] qown [NUM_REGIONS];
  logic [NUM_CH-1:0]  chen, ien, pend;
  logic [NUM_QCH-1:0] qen;

  logic [NUM_CH-1:0]  ownSel, effMask, halfSel, wrKeep, wrBits, rd64, rdMasked;
  logic [NUM_QCH-1:0] qEff;
  logic [DATA_W-1:0]  rdWord, halfOwn;

  assign ownSel  = own[st.region];
  assign effMask = st.shadow ? ownSel : '1;
  assign qEff    = st.shadow ? qown[st.region] : '1;
  assign halfSel = st.hiHalf ? {{DATA_W{1'b1}}, {DATA_W{1'b0}}}
                             : {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
  assign wrKeep  = effMask & halfSel;
  assign wrBits  = {wrData, wrData} & wrKeep;
  assign halfOwn = st.hiHalf ? ownSel[NUM_CH-1:DATA_W] : ownSel[DATA_W-1:0];

  // Channel bank and ownership masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chen <= '0;
      ien  <= '0;
      pend <= '0;
      qen  <= '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
        own[r]  <= '0;
        qown[r] <= '0;
      end
    end else begin
      if (st.wrChen) chen <= (chen & ~wrKeep) | wrBits;
      if (st.wrIen)       ien <= (ien & ~wrKeep) | wrBits;
      else if (st.setIen) ien <= ien | wrBits;
      else if (st.clrIen) ien <= ien & ~wrBits;
      pend <= (pend & ~(st.clrPend ? wrBits : '0)) | doneIn;
      if (st.wrQen) qen <= (qen & ~qEff) | (wrData[NUM_QCH-1:0] & qEff);
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (st.ownIdx == RIDX_W'(r)) begin
          if (st.wrOwnLo) own[r][DATA_W-1:0]      <= wrData;
          if (st.wrOwnHi) own[r][NUM_CH-1:DATA_W] <= wrData;
          if (st.wrQOwn)  qown[r]                 <= wrData[NUM_QCH-1:0];
        end
      end
    end
  end

  // Read path: select, mask, pick half
  always_comb begin
    rd64 = '0;
    case (st.rdSel)
      RD_CHEN: rd64 = chen;
      RD_IEN:  rd64 = ien;
      RD_PEND: rd64 = pend;
      default: rd64 = '0;
    endcase
    rdMasked = rd64 & effMask;
    rdWord   = st.hiHalf ? rdMasked[NUM_CH-1:DATA_W] : rdMasked[DATA_W-1:0];
    case (st.rdSel)
      RD_QEN:   rdWord = DATA_W'(qen & qEff);
      RD_OWNLO: rdWord = own[st.ownIdx][DATA_W-1:0];
      RD_OWNHI: rdWord = own[st.ownIdx][NUM_CH-1:DATA_W];
      RD_QOWN:  rdWord = DATA_W'(qown[st.ownIdx]);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= st.rdStb ? rdWord : '0;
  end

  // Per-region completion interrupts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intOut <= '0;
    else for (int r = 0; r < NUM_REGIONS; r++)
      intOut[r] <= |(pend & ien & own[r]);
  end

  assert_shadow_write_keeps_unowned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrChen && st.shadow) |=> (((chen ^ $past(chen)) & ~$past(ownSel)) == '0));

  assert_global_write_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrChen && !st.shadow) |=>
      (($past(st.hiHalf) ? chen[NUM_CH-1:DATA_W] : chen[DATA_W-1:0]) == $past(wrData)));

  assert_shadow_read_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdStb && st.shadow && st.rdSel != RD_QEN) |=> ((rdData & ~$past(halfOwn)) == '0));

  assert_pending_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn != '0) |=> ((pend & $past(doneIn)) == $past(doneIn)));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gChk
    assert_no_owner_no_int_R10: assert property (@(posedge clk) disable iff (!rstN)
      (own[g] == '0) |=> !intOut[g]);
    assert_mask_shadow_immune_R8: assert property (@(posedge clk) disable iff (!rstN)
      st.shadow |=> (own[g] == $past(own[g]) && qown[g] == $past(qown[g])));
  end
endmodule

// File: rtl/shadow_bit_filter.sv
module shadow_bit_filter
  import shadow_filter_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  input  logic [NUM_CH-1:0]      doneIn,
  output logic [NUM_REGIONS-1:0] intOut
);
  strobe_t st;

  sf_ctrl uCtrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .st   (st)
  );

  sf_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .wrData (wrData),
    .doneIn (doneIn),
    .rdData (rdData),
    .intOut (intOut)
  );
endmodule

// File: tb/shadow_bit_filter_test.sv
module shadow_bit_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] doneIn = '0;
  logic [3:0]  intOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got;

  shadow_bit_filter uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .doneIn(doneIn), .intOut(intOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] sh(int r, int off);
    return 12'((r + 1) * 256 + off);
  endfunction

  function automatic logic [11:0] ownAddr(int r, int field);
    return 12'(64 + r * 16 + field * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulseDone(logic [63:0] v);
    @(negedge clk);
    doneIn = v;
    @(negedge clk);
    doneIn = '0;
  endtask

  task automatic testReset();
    check("R1 intOut", 32'(intOut), 32'h0);
    check("R1 rdData", rdData, 32'h0);
    busRead(12'h000, got); check("R1 chen lo", got, 32'h0);
    busRead(ownAddr(0, 0), got); check("R1 mask r0 lo", got, 32'h0);
  endtask

  task automatic testGlobal();
    busWrite(12'h000, 32'hA5A5A5A5);
    busWrite(12'h004, 32'h12345678);
    busRead(12'h000, got); check("R2 chen lo", got, 32'hA5A5A5A5);
    busRead(12'h004, got); check("R2 chen hi", got, 32'h12345678);
  endtask

  task automatic testNoOwner();
    busRead(sh(1, 'h00), got); check("R3 unowned read", got, 32'h0);
    busWrite(sh(1, 'h00), 32'hFFFFFFFF);
    busRead(12'h000, got); check("R4 unowned write", got, 32'hA5A5A5A5);
  endtask

  task automatic testLowOwner();
    busWrite(ownAddr(1, 0), 32'h0000FFFF);
    busRead(ownAddr(1, 0), got); check("R2 mask readback", got, 32'h0000FFFF);
    busRead(sh(1, 'h00), got); check("R3 partial read", got, 32'h0000A5A5);
    busWrite(sh(1, 'h00), 32'h00000000);
    busRead(12'h000, got); check("R4 partial write", got, 32'hA5A50000);
  endtask

  task automatic testHighHalf();
    busWrite(ownAddr(2, 1), 32'hFF000000);
    busWrite(sh(2, 'h04), 32'hFFFFFFFF);
    busRead(12'h004, got); check("R6 hi merge", got, 32'hFF345678);
    busWrite(sh(2, 'h00), 32'hFFFFFFFF);
    busRead(12'h000, got); check("R6 lo untouched", got, 32'hA5A50000);
    busRead(sh(2, 'h04), got); check("R6 hi read", got, 32'hFF000000);
  endtask

  task automatic testSetClr();
    busWrite(sh(1, 'h10), 32'hFFFFFFFF);
    busRead(12'h008, got); check("R5 set masked", got, 32'h0000FFFF);
    busWrite(sh(1, 'h18), 32'h000000FF);
    busRead(12'h008, got); check("R5 clear masked", got, 32'h0000FF00);
    busWrite(sh(0, 'h18), 32'hFFFFFFFF);
    busRead(12'h008, got); check("R5 clear unowned", got, 32'h0000FF00);
  endtask

  task automatic testQdma();
    busWrite(ownAddr(3, 2), 32'h5);
    busWrite(sh(3, 'h30), 32'hF);
    busRead(12'h030, got); check("R7 qdma merge", got, 32'h5);
    busWrite(12'h030, 32'hF);
    busRead(sh(3, 'h30), got); check("R7 qdma read", got, 32'h5);
  endtask

  task automatic testMaskGuard();
    busWrite(sh(1, 'h40), 32'hFFFFFFFF);
    busRead(ownAddr(0, 0), got); check("R8 shadow write ignored", got, 32'h0);
    busRead(sh(0, 'h50), got); check("R8 shadow read zero", got, 32'h0);
  endtask

  task automatic testInterrupts();
    pulseDone(64'h100);
    @(negedge clk);
    check("R10 int from owned", 32'(intOut), 32'h2);
    busWrite(sh(2, 'h28), 32'h100);
    busRead(12'h020, got); check("R9 unowned clear kept", got, 32'h100);
    check("R10 int held", 32'(intOut), 32'h2);
    busWrite(sh(1, 'h28), 32'h100);
    busRead(12'h020, got); check("R9 owned clear", got, 32'h0);
    check("R10 int dropped", 32'(intOut), 32'h0);
    busWrite(12'h014, 32'h10000000);
    pulseDone(64'h1000_0000_0000_0000);
    @(negedge clk);
    check("R10 hi channel int", 32'(intOut), 32'h4);
  endtask

  task automatic testSetWins();
    @(negedge clk);
    wrEn = 1'b1; addr = 12'h02C; wrData = 32'h10000000;
    doneIn = 64'h1000_0000_0000_0000;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; doneIn = '0;
    busRead(12'h024, got); check("R9 set wins", got, 32'h10000000);
    busWrite(12'h02C, 32'h10000000);
    busRead(12'h024, got); check("R9 global clear", got, 32'h0);
    @(negedge clk);
    check("R10 int clear", 32'(intOut), 32'h0);
  endtask

  task automatic testUnmapped();
    busWrite(12'hF00, 32'hFFFFFFFF);
    busRead(12'h000, got); check("R11 unmapped write", got, 32'hA5A50000);
    busRead(12'hF00, got); check("R11 unmapped read", got, 32'h0);
    busRead(12'h000, got);
    @(negedge clk);
    check("R11 rdData idle", rdData, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGlobal();
    testNoOwner();
    testLowOwner();
    testHighHalf();
    testSetClr();
    testQdma();
    testMaskGuard();
    testInterrupts();
    testSetWins();
    testUnmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule